// File: doc/BRIEF.md
# Multi-Entry DRAM Row Buffer Cache

This block is the front end of a single DRAM bank model. It keeps several open rows at once rather than the usual single row buffer. Each request names a row, a column, a direction and write data. The block compares the row against every open-row entry at the same time. A request that matches is served from that entry after the column-access delay and never touches the cell array.

A request that matches no entry takes a slot. An empty slot is used first. When no slot is empty, the least recently used row is evicted. If the evicted row holds modified data, or if the bank is built with destructive reads, that row is first copied back to the cell array. The bank then runs precharge, activate and column access, each with its own cycle count, and loads the new row into the slot.

Requests enter through a valid/ready handshake, one at a time. Each request ends with a single-cycle response pulse that carries the data word and a flag that says whether the request hit. The cell array is a small internal memory. At reset every word holds a known pattern.

Top module: `rbc_bank`

## Requirements
- R1: `req_ready` is high only while no request is in progress, so a second request is not accepted until the first has responded. Every accepted request produces exactly one `rsp_valid` pulse, one cycle wide.
- R2: After reset every entry is empty, `req_ready` is 1 and `rsp_valid` is 0, so the first access to any row misses.
- R3: A request whose row is held in any entry hits. It responds with `rsp_hit`=1 exactly T_CAS cycles after the accepting clock edge (3 by default). At most one entry holds a given row.
- R4: A miss whose victim slot is empty or unmodified responds with `rsp_hit`=0 exactly T_PRE+T_ACT+T_CAS cycles after acceptance (9 by default).
- R5: A miss whose victim holds modified data takes one extra write-back cycle (10 by default). A later read of the evicted row returns the modified data.
- R6: Empty slots are filled first, lowest index first. After that the victim is the least recently used entry, and both hits and fills count as uses.
- R7: After reset, array word (row r, column c) holds 16'hC300 XOR {r[7:0], c[7:0]} for the default 16-bit word, and a read returns that word.
- R8: A write stores `req_wdata` into the addressed column of the entry, marks the entry modified and echoes the written word on `rsp_rdata`. Other columns of that row keep their values.
- R9: With DESTRUCTIVE=1, filling an entry clears the row in the array. Every eviction of a valid entry is then written back, clean or not, taking the extra cycle, and the row's data survives the round trip.
- R10: With ENTRIES=1 the bank acts as a single row buffer. A repeat access to the open row hits, and an access to any other row misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The bank can take a request this cycle |
| req_row | input | $clog2(ROWS) | Row number of the request |
| req_col | input | $clog2(COLS) | Column (word) within the row |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Word to write |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | The request was served from an open entry |
| rsp_rdata | output | DW | Word read, or the word written |

## Verification
The hardest state to reach from the ports is the eviction of a modified row. The stimulus has to write into an open row, then keep that row out of use while exactly enough other rows are filled and touched that it becomes the least recently used entry, and only then force one more miss. The directed sequence tracks the recency order by hand through hits and fills. It checks which rows miss, since a miss proves a row was evicted, and it checks the extra write-back cycle. The evicted row is then read back, which shows that the modified word reached the array. A second instance with one entry and destructive reads shows that even clean rows survive the trip through the array.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

  typedef enum logic [2:0] {
    BK_IDLE = 3'd0,
    BK_WB   = 3'd1,
    BK_PRE  = 3'd2,
    BK_ACT  = 3'd3,
    BK_CAS  = 3'd4
  } bank_state_e;

  // Reset content of one array word, before truncation to the word width.
  function automatic logic [31:0] init_word(input int unsigned r, input int unsigned c);
    logic [31:0] w;
    w = ({24'd0, r[7:0]} << 8) | {24'd0, c[7:0]};
    return w ^ 32'h0000_C300;
  endfunction

endpackage

// File: rtl/rbc_cells.sv
module rbc_cells #(
  parameter int ROWS = 16,
  parameter int COLS = 4,
  parameter int DW   = 16,
  localparam int RBW = $clog2(ROWS),
  localparam int RW  = COLS * DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RBW-1:0] rd_row,
  output logic [RW-1:0]  rd_data,
  input  logic           wr_en,
  input  logic [RBW-1:0] wr_row,
  input  logic [RW-1:0]  wr_data,
  input  logic           clr_en,
  input  logic [RBW-1:0] clr_row
);
  logic [RW-1:0] mem [ROWS];

  assign rd_data = mem[rd_row];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          mem[r][c*DW +: DW] <= DW'(rbc_pkg::init_word(r, c));
    end else begin
      if (wr_en)  mem[wr_row]  <= wr_data;
      if (clr_en) mem[clr_row] <= '0;
    end
  end
endmodule

// File: rtl/rbc_match.sv
module rbc_match #(
  parameter int ENTRIES = 4,
  parameter int RBW     = 4,
  localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]          ent_valid,
  input  logic [ENTRIES-1:0][RBW-1:0] ent_tag,
  input  logic [RBW-1:0]              row,
  output logic [ENTRIES-1:0]          hit_vec,
  output logic                        hit_any,
  output logic [AW-1:0]               hit_way,
  output logic                        free_any,
  output logic [AW-1:0]               free_way
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = ent_valid[i] && (ent_tag[i] == row);
  end

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    free_any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_way = AW'(i);
      if (!ent_valid[i]) begin
        free_way = AW'(i);
        free_any = 1'b1;
      end
    end
  end

  assign hit_any = |hit_vec;
endmodule

// File: rtl/rbc_lru.sv
module rbc_lru #(
  parameter int ENTRIES = 4,
  localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch,
  input  logic [AW-1:0]      touch_way,
  output logic [AW-1:0]      victim_way,
  output logic [ENTRIES-1:0] oldest_vec
);
  logic [AW-1:0] age [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age[i] <= AW'(i);
    end else if (touch) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (AW'(i) == touch_way)       age[i] <= '0;
        else if (age[i] < age[touch_way]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_old
    assign oldest_vec[i] = (age[i] == AW'(ENTRIES - 1));
  end

  always_comb begin
    victim_way = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (oldest_vec[i]) victim_way = AW'(i);
  end

  // R6
  single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/rbc_bank.sv
module rbc_bank #(
  parameter int ENTRIES     = 4,
  parameter int ROWS        = 16,
  parameter int COLS        = 4,
  parameter int DW          = 16,
  parameter int T_PRE       = 3,
  parameter int T_ACT       = 3,
  parameter int T_CAS       = 3,
  parameter bit DESTRUCTIVE = 1'b0,
  localparam int RBW  = $clog2(ROWS),
  localparam int CLW  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int RW   = COLS * DW,
  localparam int AW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int TMAX = (T_PRE > T_ACT) ? ((T_PRE > T_CAS) ? T_PRE : T_CAS)
                                        : ((T_ACT > T_CAS) ? T_ACT : T_CAS),
  localparam int CW   = $clog2(TMAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [RBW-1:0] req_row,
  input  logic [CLW-1:0] req_col,
  input  logic           req_we,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  output logic           rsp_hit,
  output logic [DW-1:0]  rsp_rdata
);
  import rbc_pkg::*;

  bank_state_e state;
  logic [CW-1:0] cnt;

  logic [ENTRIES-1:0]          ent_valid, ent_dirty;
  logic [ENTRIES-1:0][RBW-1:0] ent_tag;
  logic [ENTRIES-1:0][RW-1:0]  ent_data;

  logic [RBW-1:0] r_row;
  logic [CLW-1:0] r_col;
  logic           r_we, r_hit;
  logic [DW-1:0]  r_wd;
  logic [AW-1:0]  r_way;

  logic [ENTRIES-1:0] hit_vec, oldest_vec;
  logic               hit_any, free_any;
  logic [AW-1:0]      hit_way, free_way, lru_way, pick_way;
  logic [RW-1:0]      arr_rd;

  // Named internal events
  logic accept, wb_evt, fill_evt, cas_done, need_wb;

  assign req_ready = (state == BK_IDLE);
  assign accept    = req_valid && req_ready;
  assign pick_way  = hit_any ? hit_way : (free_any ? free_way : lru_way);
  assign need_wb   = ent_valid[pick_way] && (ent_dirty[pick_way] || DESTRUCTIVE);
  assign wb_evt    = (state == BK_WB);
  assign fill_evt  = (state == BK_ACT) && (cnt == '0);
  assign cas_done  = (state == BK_CAS) && (cnt == '0);

  rbc_match #(.ENTRIES(ENTRIES), .RBW(RBW)) u_match (
    .ent_valid(ent_valid), .ent_tag(ent_tag), .row(req_row),
    .hit_vec(hit_vec), .hit_any(hit_any), .hit_way(hit_way),
    .free_any(free_any), .free_way(free_way)
  );

  rbc_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(accept), .touch_way(pick_way),
    .victim_way(lru_way), .oldest_vec(oldest_vec)
  );

  rbc_cells #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_cells (
    .clk(clk), .rst_n(rst_n), .rd_row(r_row), .rd_data(arr_rd),
    .wr_en(wb_evt), .wr_row(ent_tag[r_way]), .wr_data(ent_data[r_way]),
    .clr_en(fill_evt && DESTRUCTIVE), .clr_row(r_row)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= BK_IDLE;
      cnt       <= '0;
      ent_valid <= '0;
      ent_dirty <= '0;
      ent_tag   <= '0;
      ent_data  <= '0;
      r_row <= '0; r_col <= '0; r_we <= 1'b0; r_hit <= 1'b0;
      r_wd  <= '0; r_way <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        BK_IDLE: if (accept) begin
          r_row <= req_row; r_col <= req_col; r_we <= req_we;
          r_wd  <= req_wdata; r_way <= pick_way; r_hit <= hit_any;
          if (hit_any) begin
            state <= BK_CAS; cnt <= CW'(T_CAS - 1);
          end else if (need_wb) begin
            state <= BK_WB;
          end else begin
            state <= BK_PRE; cnt <= CW'(T_PRE - 1);
          end
        end
        BK_WB: begin
          ent_dirty[r_way] <= 1'b0;
          state <= BK_PRE; cnt <= CW'(T_PRE - 1);
        end
        BK_PRE: begin
          if (cnt == '0) begin state <= BK_ACT; cnt <= CW'(T_ACT - 1); end
          else cnt <= cnt - 1'b1;
        end
        BK_ACT: begin
          if (fill_evt) begin
            ent_data[r_way]  <= arr_rd;
            ent_tag[r_way]   <= r_row;
            ent_valid[r_way] <= 1'b1;
            ent_dirty[r_way] <= 1'b0;
            state <= BK_CAS; cnt <= CW'(T_CAS - 1);
          end else cnt <= cnt - 1'b1;
        end
        BK_CAS: begin
          if (cas_done) begin
            if (r_we) begin
              ent_data[r_way][int'(r_col)*DW +: DW] <= r_wd;
              ent_dirty[r_way] <= 1'b1;
              rsp_rdata <= r_wd;
            end else begin
              rsp_rdata <= ent_data[r_way][int'(r_col)*DW +: DW];
            end
            rsp_valid <= 1'b1;
            rsp_hit   <= r_hit;
            state     <= BK_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: state <= BK_IDLE;
      endcase
    end
  end

  // R1
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R3
  one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R3
  hit_to_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit_any) |=> (state == BK_CAS));
  // R5
  wb_before_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |-> !(ent_valid[r_way] && ent_dirty[r_way]));
endmodule

// File: tb/sim_rbc_bank.sv
module sim_rbc_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        vld   [2];
  logic        rdy   [2];
  logic [3:0]  rrow  [2];
  logic [1:0]  rcol  [2];
  logic        rwe   [2];
  logic [15:0] rwd   [2];
  logic        rv    [2];
  logic        rhit  [2];
  logic [15:0] rdat  [2];

  int total = 0;
  int bad   = 0;

  rbc_bank u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(vld[0]), .req_ready(rdy[0]),
    .req_row(rrow[0]), .req_col(rcol[0]), .req_we(rwe[0]), .req_wdata(rwd[0]),
    .rsp_valid(rv[0]), .rsp_hit(rhit[0]), .rsp_rdata(rdat[0])
  );

  rbc_bank #(.ENTRIES(1), .DESTRUCTIVE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(vld[1]), .req_ready(rdy[1]),
    .req_row(rrow[1]), .req_col(rcol[1]), .req_we(rwe[1]), .req_wdata(rwd[1]),
    .rsp_valid(rv[1]), .rsp_hit(rhit[1]), .rsp_rdata(rdat[1])
  );

  function automatic logic [15:0] iw(input int r, input int c);
    return {r[7:0], c[7:0]} ^ 16'hC300;
  endfunction

  localparam int HIT  = 3;
  localparam int MISS = 3 + 3 + 3;
  localparam int DWB  = MISS + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input int w, input int row, input int col, input bit we,
                        input logic [15:0] wd, input bit exp_hit, input int exp_lat,
                        input logic [15:0] exp_d, input string req);
    int n;
    bit got;
    @(negedge clk);
    check(rdy[w] == 1'b1, "R1", "ready before request", int'(rdy[w]), 1);
    vld[w] = 1'b1; rrow[w] = 4'(row); rcol[w] = 2'(col); rwe[w] = we; rwd[w] = wd;
    @(posedge clk);
    @(negedge clk);
    vld[w] = 1'b0;
    check(rdy[w] == 1'b0, "R1", "ready while busy", int'(rdy[w]), 0);
    n = 0; got = 1'b0;
    while (!got && n < 60) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (rv[w]) got = 1'b1;
    end
    check(n == exp_lat, req, "latency", n, exp_lat);
    check(rhit[w] == exp_hit, req, "hit flag", int'(rhit[w]), int'(exp_hit));
    check(rdat[w] == exp_d, req, "data", int'(rdat[w]), int'(exp_d));
    @(posedge clk);
    @(negedge clk);
    check(rv[w] == 1'b0, "R1", "single pulse", int'(rv[w]), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(rdy[0] == 1'b1, "R2", "ready after reset", int'(rdy[0]), 1);
    check(rv[0] == 1'b0, "R2", "no response after reset", int'(rv[0]), 0);
    check(rdy[1] == 1'b1, "R2", "ready after reset u1", int'(rdy[1]), 1);
  endtask

  task automatic t_fill_hit();
    access(0, 1, 0, 0, 16'h0, 0, MISS, iw(1, 0), "R2 R4 R7");
    access(0, 1, 2, 0, 16'h0, 1, HIT, iw(1, 2), "R3");
    access(0, 2, 0, 0, 16'h0, 0, MISS, iw(2, 0), "R6");
    access(0, 3, 0, 0, 16'h0, 0, MISS, iw(3, 0), "R6");
    access(0, 4, 0, 0, 16'h0, 0, MISS, iw(4, 0), "R6");
    access(0, 1, 1, 0, 16'h0, 1, HIT, iw(1, 1), "R3");
    access(0, 3, 1, 1, 16'hBEEF, 1, HIT, 16'hBEEF, "R8");
  endtask

  task automatic t_lru_order();
    // age order oldest->newest: 2,4,1,3
    access(0, 5, 0, 0, 16'h0, 0, MISS, iw(5, 0), "R6");
    access(0, 2, 0, 0, 16'h0, 0, MISS, iw(2, 0), "R6");   // row 2 had been evicted
    access(0, 1, 3, 0, 16'h0, 1, HIT, iw(1, 3), "R6");    // row 1 kept by recent hit
    access(0, 3, 1, 0, 16'h0, 1, HIT, 16'hBEEF, "R8");
  endtask

  task automatic t_dirty_evict();
    // order: 5,2,1,3 -> fill 6,7,8 leaves modified row 3 oldest
    access(0, 6, 0, 0, 16'h0, 0, MISS, iw(6, 0), "R4");
    access(0, 7, 0, 0, 16'h0, 0, MISS, iw(7, 0), "R4");
    access(0, 8, 0, 0, 16'h0, 0, MISS, iw(8, 0), "R4");
    access(0, 9, 2, 0, 16'h0, 0, DWB, iw(9, 2), "R5");
    access(0, 3, 1, 0, 16'h0, 0, MISS, 16'hBEEF, "R5");
    access(0, 3, 0, 0, 16'h0, 1, HIT, iw(3, 0), "R8");
  endtask

  task automatic t_destructive();
    access(1, 2, 3, 0, 16'h0, 0, MISS, iw(2, 3), "R10");
    access(1, 2, 0, 0, 16'h0, 1, HIT, iw(2, 0), "R10");
    access(1, 5, 1, 0, 16'h0, 0, DWB, iw(5, 1), "R9");
    access(1, 2, 3, 0, 16'h0, 0, DWB, iw(2, 3), "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      vld[i] = 1'b0; rrow[i] = '0; rcol[i] = '0; rwe[i] = 1'b0; rwd[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill_hit();
    t_lru_order();
    t_dirty_evict();
    t_destructive();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule